// File: doc/BRIEF.md
# DMA Word Address and Transfer Count Registers

This block holds the two programmable registers that a DMA transfer engine reads before it starts: a word address into memory and a transfer count with its direction and enable controls. Both are written by the host processor as memory-mapped registers, and a separate register-select strobe qualifies each one.

The address register is unusual in that it takes nothing from the data bus. The value is carried on the address lines of the write cycle itself. Bus address bit 14 selects which half is updated. When it is high, the upper part of the DMA address is replaced. When it is low, the lower part is replaced. The other half is kept in both cases. The count register is loaded from the data bus. The count is incremented once straight after the load, so the engine sees one more than the value written. The count can be read back, with its two top bits always reading as one.

The transfer engine that consumes these values is outside this block.

Top module: `dma_xfer_regs`

## Requirements
- R1: While reset (active low, synchronous) is held, and on the first cycle after it, the DMA address, count, direction and enable outputs are all zero, and the count read data is 0xC000.
- R2: On an address write with bus address bit 14 high, DMA address bits [21:9] take bus address bits [13:1] on the next cycle, and DMA address bits [8:0] keep their value.
- R3: On an address write with bus address bit 14 low, DMA address bits [8:1] take bus address bits [8:1] on the next cycle, and DMA address bits [21:9] keep their value.
- R4: DMA address bit 0 is always zero.
- R5: On a count write, the count becomes data bits [13:0] plus one on the next cycle, wrapping within 14 bits, so that a written 0x3FFF gives 0.
- R6: On a count write, the direction output takes data bit 14 and the enable output takes data bit 15 on the next cycle.
- R7: The count read data always equals {2'b11, count}.
- R8: A register whose write strobe is low keeps its value. An address write leaves count, direction and enable unchanged, and a count write leaves the address unchanged.
- R9: On an address write, bus address bits [23:15] and bit 0 have no effect. On a low-half write, bus address bits [13:9] also have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 24 | Bus address of the write cycle; it carries the address register value |
| bus_wdata | input | 16 | Bus write data, used by count writes |
| addr_wr | input | 1 | Write strobe for the address register |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_rdata | output | 16 | Count register read data |
| dma_addr | output | 22 | DMA word address |
| dma_count | output | 14 | DMA transfer count |
| dma_dir | output | 1 | Transfer direction flag |
| dma_en | output | 1 | DMA enable |

## Verification
The assertions treat each write strobe as valid for exactly one sampled clock edge. They assume the bus address and data are settled at that edge and that both strobes may be high in the same cycle. The hold checks also assume reset is not asserted in the middle of a write.

The bench changes inputs only on the falling edge and holds every strobe for a single cycle. It also exercises both strobes in the same cycle. Reset is applied only while both strobes are low, so the stimulus never leaves these assumptions.

// File: rtl/dma_xfer_regs_pkg.sv
// Package: shared control type for the DMA register block.
// Assumes nothing beyond a two-bit direction/enable pair per channel.
package dma_xfer_regs_pkg;
    // Direction and enable controls latched with the count.
    typedef struct packed {
        logic en;
        logic dir;
    } dma_ctl_t;
endpackage

// File: rtl/dma_xfer_addr_reg.sv
// Module: DMA word address register, loaded through the bus address lines.
// A high select bit replaces the upper field and a low one replaces the lower field.
// Bit 0 is tied to zero because transfers are word aligned.
// Assumes the caller slices the bus address so that hi_src and lo_src line up with the fields.
module dma_xfer_addr_reg #(
    parameter int HI_W = 13,
    parameter int LO_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  sel_hi,
    input  logic [HI_W-1:0]       hi_src,
    input  logic [LO_W-1:0]       lo_src,
    output logic [HI_W+LO_W:0]    addr
);
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;

    // Upper field: updated only by writes with the select bit high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (wr && sel_hi)
            hi_q <= hi_src;
    end

    // Lower field: updated only by writes with the select bit low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (wr && !sel_hi)
            lo_q <= lo_src;
    end

    // Join the two fields over a constant zero word-offset bit.
    assign addr = {hi_q, lo_q, 1'b0};
endmodule

// File: rtl/dma_xfer_count_reg.sv
// Module: DMA transfer count with direction and enable controls.
// A write stores the data count field plus one, wrapping within CNT_W bits.
// Read data sets every bit above the count field to one.
// Assumes DW == CNT_W + 2: the direction bit sits just above the count and enable is the top bit.
module dma_xfer_count_reg
    import dma_xfer_regs_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic [CNT_W-1:0] count,
    output dma_ctl_t         ctl,
    output logic [DW-1:0]    rdata
);
    localparam int DIR_BIT = CNT_W;
    localparam int EN_BIT  = CNT_W + 1;
    localparam int PAD_W   = DW - CNT_W;

    logic [CNT_W-1:0] cnt_q;
    dma_ctl_t         ctl_q;
    logic [CNT_W-1:0] load_val;

    // Increment applied at load time; the sum is truncated, so it wraps.
    assign load_val = wdata[CNT_W-1:0] + CNT_W'(1);

    // Count and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ctl_q <= '0;
        end else if (wr) begin
            cnt_q     <= load_val;
            ctl_q.dir <= wdata[DIR_BIT];
            ctl_q.en  <= wdata[EN_BIT];
        end
    end

    assign count = cnt_q;
    assign ctl   = ctl_q;
    // Read path: the bits above the count always read as one.
    assign rdata = {{PAD_W{1'b1}}, cnt_q};
endmodule

// File: rtl/dma_xfer_regs.sv
// Module: top of the DMA address/count register block.
// Routes the bus address fields to the address register and the data bus to the count register.
// Assumes one-cycle write strobes that have already been decoded from the register select.
module dma_xfer_regs
    import dma_xfer_regs_pkg::*;
#(
    parameter int BUS_AW  = 24,
    parameter int DW      = 16,
    parameter int CNT_W   = 14,
    parameter int DMA_AW  = 22,
    parameter int SEL_BIT = 14,
    parameter int LOW_MSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              addr_wr,
    input  logic              cnt_wr,
    output logic [DW-1:0]     cnt_rdata,
    output logic [DMA_AW-1:0] dma_addr,
    output logic [CNT_W-1:0]  dma_count,
    output logic              dma_dir,
    output logic              dma_en
);
    localparam int HI_W = DMA_AW - LOW_MSB - 1;
    localparam int LO_W = LOW_MSB;

    dma_ctl_t ctl;
    logic     unused_bus_bits;

    // These bus address bits never reach a register.
    assign unused_bus_bits = ^{bus_addr[BUS_AW-1:SEL_BIT+1], bus_addr[0]};

    dma_xfer_addr_reg #(.HI_W(HI_W), .LO_W(LO_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (addr_wr),
        .sel_hi (bus_addr[SEL_BIT]),
        .hi_src (bus_addr[HI_W:1]),
        .lo_src (bus_addr[LO_W:1]),
        .addr   (dma_addr)
    );

    dma_xfer_count_reg #(.CNT_W(CNT_W), .DW(DW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cnt_wr),
        .wdata (bus_wdata),
        .count (dma_count),
        .ctl   (ctl),
        .rdata (cnt_rdata)
    );

    assign dma_dir = ctl.dir;
    assign dma_en  = ctl.en;
endmodule

// File: rtl/dma_xfer_regs_chk.sv
// Module: property checker for dma_xfer_regs, attached with bind.
// Assumes one-cycle write strobes and no reset in the middle of a write.
module dma_xfer_regs_chk #(
    parameter int BUS_AW = 24,
    parameter int DW     = 16,
    parameter int CNT_W  = 14,
    parameter int DMA_AW = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              addr_wr,
    input logic              cnt_wr,
    input logic [DW-1:0]     cnt_rdata,
    input logic [DMA_AW-1:0] dma_addr,
    input logic [CNT_W-1:0]  dma_count,
    input logic              dma_dir,
    input logic              dma_en
);
    // R2: a high-half write replaces bits 21:9 and keeps bits 8:0.
    assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && bus_addr[14]) |=>
            (dma_addr[21:9] == $past(bus_addr[13:1])) && (dma_addr[8:0] == $past(dma_addr[8:0])));

    // R3: a low-half write replaces bits 8:1 and keeps bits 21:9.
    assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !bus_addr[14]) |=>
            (dma_addr[8:1] == $past(bus_addr[8:1])) && (dma_addr[21:9] == $past(dma_addr[21:9])));

    // R4: the word address is always even.
    assert_even_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_addr[0] == 1'b0);

    // R5: the count becomes the written value plus one.
    assert_count_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> dma_count == CNT_W'($past(bus_wdata[CNT_W-1:0]) + CNT_W'(1)));

    // R6: the direction and enable follow data bits 14 and 15.
    assert_ctl_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (dma_dir == $past(bus_wdata[14])) && (dma_en == $past(bus_wdata[15])));

    // R7: the read data carries the count with its two top bits set.
    assert_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rdata[DW-1:CNT_W] == 2'b11) && (cnt_rdata[CNT_W-1:0] == dma_count));

    // R8: the address holds when its strobe is low.
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_wr |=> $stable(dma_addr));

    // R8: the count and controls hold when their strobe is low.
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ($stable(dma_count) && $stable(dma_dir) && $stable(dma_en)));
endmodule

bind dma_xfer_regs dma_xfer_regs_chk #(
    .BUS_AW(BUS_AW), .DW(DW), .CNT_W(CNT_W), .DMA_AW(DMA_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .addr_wr   (addr_wr),
    .cnt_wr    (cnt_wr),
    .cnt_rdata (cnt_rdata),
    .dma_addr  (dma_addr),
    .dma_count (dma_count),
    .dma_dir   (dma_dir),
    .dma_en    (dma_en)
);

// File: tb/dma_xfer_regs_bench.sv
// Bench: a behavioural model updated on every clock, with all outputs compared after each edge.
module dma_xfer_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        addr_wr = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_rdata;
    logic [21:0] dma_addr;
    logic [13:0] dma_count;
    logic        dma_dir;
    logic        dma_en;

    int tests = 0;
    int fails = 0;
    int m_addr = 0;
    int m_cnt = 0;
    int m_dir = 0;
    int m_en = 0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    dma_xfer_regs u_dma_xfer_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .addr_wr(addr_wr), .cnt_wr(cnt_wr), .cnt_rdata(cnt_rdata),
        .dma_addr(dma_addr), .dma_count(dma_count), .dma_dir(dma_dir), .dma_en(dma_en)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Compare every output against the model; the tags name what the last cycle exercised.
    task automatic compare(input string ta, input string tc);
        check({ta, " addr"}, int'(dma_addr), m_addr);
        check({tc, " count"}, int'(dma_count), m_cnt);
        check({tc, " R6 dir"}, int'(dma_dir), m_dir);
        check({tc, " R6 en"}, int'(dma_en), m_en);
        check("R7 rdata", int'(cnt_rdata), 32'hC000 | m_cnt);
        check("R4 bit0", int'(dma_addr[0]), 0);
    endtask

    // Run one clock with the given inputs, update the model, then compare after the edge.
    task automatic cycle(input logic rn, input logic aw, input logic [23:0] a,
                         input logic cw, input logic [15:0] d,
                         input string ta, input string tc);
        rst_n = rn; addr_wr = aw; bus_addr = a; cnt_wr = cw; bus_wdata = d;
        @(posedge clk);
        if (!rn) begin
            m_addr = 0; m_cnt = 0; m_dir = 0; m_en = 0;
        end else begin
            if (aw) begin
                if (a[14]) m_addr = (m_addr & 'h1FE) | ((int'(a) & 'h3FFE) << 8);
                else       m_addr = (m_addr & 'h3FFE00) | (int'(a) & 'h1FE);
            end
            if (cw) begin
                m_cnt = ((int'(d) & 'h3FFF) + 1) & 'h3FFF;
                m_dir = (int'(d) >> 14) & 1;
                m_en  = (int'(d) >> 15) & 1;
            end
        end
        @(negedge clk);
        compare(ta, tc);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state.
        cycle(1'b0, 1'b0, 24'h0, 1'b0, 16'h0, "R1", "R1");
        cycle(1'b0, 1'b0, 24'h0, 1'b0, 16'h0, "R1", "R1");
        cycle(1'b1, 1'b0, 24'h0, 1'b0, 16'h0, "R1", "R1");
        // R2: high half.
        cycle(1'b1, 1'b1, 24'h007ABE, 1'b0, 16'h0, "R2", "R8");
        // R3 and R9: low half with junk in the upper bits, bits 13:9 and bit 0.
        cycle(1'b1, 1'b1, 24'hFFA1FF, 1'b0, 16'h0, "R3 R9", "R8");
        // R9: high half with junk in the upper bits and bit 0.
        cycle(1'b1, 1'b1, 24'hABFFFF, 1'b0, 16'h0, "R2 R9", "R8");
        cycle(1'b1, 1'b1, 24'h000054, 1'b0, 16'h0, "R3", "R8");
        cycle(1'b1, 1'b1, 24'h004002, 1'b0, 16'h0, "R2", "R8");
        // R5: count load with increment, including the wrap.
        cycle(1'b1, 1'b0, 24'h004FFF, 1'b1, 16'h0123, "R8", "R5");
        cycle(1'b1, 1'b0, 24'h0, 1'b1, 16'h3FFF, "R8", "R5 wrap");
        cycle(1'b1, 1'b0, 24'h0, 1'b1, 16'h8010, "R8", "R5 R6 en");
        cycle(1'b1, 1'b0, 24'h0, 1'b1, 16'h7FFE, "R8", "R5 R6 dir");
        cycle(1'b1, 1'b0, 24'h0, 1'b1, 16'hC000, "R8", "R5 R6 both");
        // Both strobes in the same cycle.
        cycle(1'b1, 1'b1, 24'h0051FE, 1'b1, 16'h4ABC, "R2", "R5");
        cycle(1'b1, 1'b1, 24'h00BFFF, 1'b1, 16'hFFFF, "R3", "R5 wrap");
        // R8: idle cycles with changing bus values.
        for (int i = 0; i < 6; i++)
            cycle(1'b1, 1'b0, 24'(i * 24'h12345), 1'b0, 16'(i * 16'h1357), "R8", "R8");
        // A series of writes to both halves and to the count.
        for (int i = 0; i < 16; i++) begin
            cycle(1'b1, 1'b1, 24'(i * 24'h0731F) | 24'h004000, 1'b0, 16'h0, "R2", "R8");
            cycle(1'b1, 1'b1, 24'(i * 24'h00A5) & 24'hFFBFFF, 1'b1, 16'(i * 16'h2F1D), "R3", "R5");
        end
        // R1: reset in the middle of the run clears everything.
        cycle(1'b1, 1'b0, 24'h0, 1'b1, 16'hC123, "R8", "R6");
        cycle(1'b0, 1'b0, 24'h0, 1'b0, 16'h0, "R1", "R1");
        cycle(1'b1, 1'b0, 24'h0, 1'b0, 16'h0, "R1", "R1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule